// File: doc/BRIEF.md
# Handshake-to-Credit Link Adapter

This block sits at the boundary between a source that uses a valid/ready handshake and a downstream link that is flow-controlled by credits. Beats offered upstream go into a small staging FIFO. From there the block launches them onto the downstream link. It sends only while it holds credit for the far receiver. The receiver returns a one-cycle pulse for every buffer slot it frees.

The credit counter starts at the receiver's buffer depth, which is set by a parameter. The counter loses one unit per launched beat and gains one unit per return pulse. Upstream backpressure depends only on how full the staging FIFO is, so the ready output never follows upstream valid through logic.

While credit lasts, a FIFO of two or more entries passes one beat per clock. When credit runs out, beats collect in the FIFO until ready drops.

Top module: `vr_credit_bridge`

## Requirements
- R1: A beat enters the bridge only on a clock edge where `in_valid` and `in_ready` are both high. A beat offered while `in_ready` is low is not taken and is never launched.
- R2: `in_ready` is low exactly when the staging FIFO holds `DEPTH` beats. It is a register-derived signal that does not depend on `in_valid`.
- R3: A beat is launched (`out_valid` high for one cycle with its data on `out_data`) only while the credit count is above zero. Each launch uses one credit.
- R4: Each cycle with `credit_ret` high adds one credit, which allows one more launch.
- R5: After reset the credit count equals `CREDITS`, `out_valid` is low and `in_ready` is high. With no returns, exactly `CREDITS` beats can be launched.
- R6: Beats are launched in exactly the order they were accepted, with their data unchanged.
- R7: A return pulse in the same cycle as a launch leaves the credit count unchanged.
- R8: The credit count never exceeds `CREDITS`.
- R9: With the FIFO empty and credit available, a beat accepted at clock edge k appears on `out_valid` after edge k+1. A back-to-back stream passes at one beat per cycle without `in_ready` dropping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream beat present |
| in_ready | output | 1 | Bridge can take a beat this cycle |
| in_data | input | W | Upstream beat payload |
| out_valid | output | 1 | One-cycle launch strobe toward the credit link |
| out_data | output | W | Launched beat payload |
| credit_ret | input | 1 | One-cycle credit return from the receiver |

## Verification
The hardest case to reach from the ports is a return pulse that lands in the same cycle as a launch while the count is down to one. To reach it, the stimulus first uses up every credit with a stuffed FIFO. It then drives return pulses on two consecutive cycles: the second pulse coincides with the first launch. The expected result is exactly two launches on adjacent cycles, and then no more.

// File: rtl/vr_credit_bridge.sv
module vr_credit_bridge #(
  parameter int W       = 32,
  parameter int DEPTH   = 4,
  parameter int CREDITS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         credit_ret
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int CW   = $clog2(CREDITS + 1);
  localparam logic [CNTW-1:0] FULL     = CNTW'(DEPTH);
  localparam logic [CW-1:0]   CRED_MAX = CW'(CREDITS);
  localparam logic [PW-1:0]   LAST     = PW'(DEPTH - 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;
  logic [CW-1:0]   credit;
  logic            push, launch;

  assign in_ready = (count != FULL);
  assign push     = in_valid && in_ready;
  assign launch   = (count != '0) && (credit != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (launch) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, launch})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit <= CRED_MAX;
    end else begin
      case ({credit_ret, launch})
        2'b10:   credit <= credit + 1'b1;
        2'b01:   credit <= credit - 1'b1;
        default: credit <= credit;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= launch;
      if (launch) out_data <= mem[rd_ptr];
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= CRED_MAX);

  a_r3_launch_spends: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(credit_ret) |-> credit == $past(credit) - CW'(1));

  a_r7_ret_with_launch: assert property (@(posedge clk) disable iff (!rst_n)
    credit_ret && launch |=> $stable(credit));

  a_r4_ret_adds: assert property (@(posedge clk) disable iff (!rst_n)
    credit_ret && !launch |=> credit == $past(credit) + CW'(1));

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);

  a_r1_hold_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |=> count <= $past(count));
endmodule

// File: tb/test_vr_credit_bridge.sv
module test_vr_credit_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16, DEPTH = 4, CREDITS = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, credit_ret = 0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_data;

  int tests = 0, fails = 0;
  int cyc = 0, launched = 0, returned = 0, pending = 0, acc_cyc = 0;
  logic [W-1:0] exp_q[$];
  int lcyc[$];

  vr_credit_bridge #(.W(W), .DEPTH(DEPTH), .CREDITS(CREDITS)) i_vr_credit_bridge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .credit_ret(credit_ret));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && credit_ret) returned <= returned + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] d);
    in_valid = 1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    exp_q.push_back(d);
    acc_cyc = cyc;
    in_valid = 0;
  endtask

  task automatic give(input int n);
    for (int i = 0; i < n; i++) begin
      credit_ret = 1; @(negedge clk);
      credit_ret = 0; @(negedge clk);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk(0, "R6 unexpected beat", out_data, 0);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R6 order/data", out_data, e);
      end
      launched++;
      lcyc.push_back(cyc);
      chk(launched <= CREDITS + returned, "R3 launch without credit", launched, CREDITS + returned);
      pending++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base, a0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1, "R5 in_ready after reset", in_ready, 1);
    chk(out_valid == 0, "R5 out_valid after reset", out_valid, 0);

    // R9: streaming with credit available
    lcyc.delete();
    send(16'h0011); a0 = acc_cyc;
    send(16'h0022);
    send(16'h0033);
    repeat (4) @(negedge clk);
    chk(lcyc.size() == 3, "R9 stream launches", lcyc.size(), 3);
    if (lcyc.size() == 3) begin
      chk(lcyc[0] == a0 + 1, "R9 latency", lcyc[0], a0 + 1);
      chk(lcyc[2] - lcyc[0] == 2, "R9 one per cycle", lcyc[2] - lcyc[0], 2);
    end
    give(3);

    // R5/R3/R2: no returns, stuff the FIFO
    base = launched;
    for (int i = 0; i < 8; i++) send(16'h0100 + 16'(i));
    repeat (5) @(negedge clk);
    chk(launched - base == CREDITS, "R5 launches equal reset credits", launched - base, CREDITS);
    chk(in_ready == 0, "R2 ready low when FIFO full", in_ready, 0);

    // R1: beat offered while not ready is ignored
    base = launched;
    in_valid = 1; in_data = 16'hDEAD;
    repeat (3) @(negedge clk);
    chk(in_ready == 0, "R1 ready stays low under valid", in_ready, 0);
    in_valid = 0;
    chk(launched == base, "R1 no launch without credit", launched - base, 0);

    // R7: return coincides with launch at credit one
    lcyc.delete();
    credit_ret = 1; @(negedge clk);
    @(negedge clk);
    credit_ret = 0; @(negedge clk);
    repeat (4) @(negedge clk);
    chk(lcyc.size() == 2, "R7 launches after two returns", lcyc.size(), 2);
    if (lcyc.size() == 2) chk(lcyc[1] - lcyc[0] == 1, "R7 adjacent launches", lcyc[1] - lcyc[0], 1);
    chk(in_ready == 1, "R2 ready back after drain", in_ready, 1);

    // R4: each pulse releases exactly one beat
    base = launched;
    give(1);
    repeat (3) @(negedge clk);
    chk(launched - base == 1, "R4 one pulse one launch", launched - base, 1);
    give(1);
    repeat (3) @(negedge clk);
    chk(launched - base == 2, "R4 second pulse", launched - base, 2);
    chk(exp_q.size() == 0, "R6 all stuffed beats out", exp_q.size(), 0);
    give(4);

    // mixed stream with echoed returns
    pending = 0;
    base = launched;
    fork
      for (int i = 0; i < 12; i++) begin
        send(16'h0200 + 16'(i));
        if (i % 5 == 4) @(negedge clk);
      end
      for (int i = 0; i < 12; i++) begin
        while (pending == 0) @(negedge clk);
        pending--;
        if (i % 3 == 1) @(negedge clk);
        credit_ret = 1; @(negedge clk);
        credit_ret = 0;
      end
    join
    repeat (6) @(negedge clk);
    chk(launched - base == 12, "R6 mixed stream delivered", launched - base, 12);
    chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);

    // R8/R4: credit back at exactly the reset value
    base = launched;
    for (int i = 0; i < 6; i++) send(16'h0300 + 16'(i));
    repeat (5) @(negedge clk);
    chk(launched - base == CREDITS, "R8 credit restored to cap", launched - base, CREDITS);
    give(2);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 remaining beats released", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule